// File: doc/BRIEF.md
# Serial-Load Bank Configuration Register File

This block sits on the processor write path of a cartridge-style memory banking unit. Every write that lands in the upper half of the 16-bit address space carries one configuration bit on data bit 0. Five of these writes build a 5-bit value, least significant bit first. On the fifth write the value is stored into one of four configuration registers. Address bits 14:13 of that fifth write pick the register.

The four registers are a mode/control word, two pattern-bank selectors and a program-bank selector. The program-bank selector keeps only four bits. A write with data bit 7 set is an escape. It drops any partly built value and forces the two program-banking mode bits of the control word to one.

The registers drive output ports directly. The translation logic that consumes them sits outside this block.

Top module: `serial_cfg_regs`

## Requirements
- R1: After synchronous reset the control output reads 0x0C, and both pattern-bank outputs and the program-bank output read 0.
- R2: A write is accepted only when the strobe is high and address bit 15 is 1. Any other cycle leaves every register and the partial value unchanged.
- R3: An accepted write with data bit 7 clear shifts data bit 0 in, so the first of five writes ends up in bit 0 of the stored value and the fifth in bit 4.
- R4: On the fifth accepted serial write, address bits 14:13 of that write select the destination: 0 gives control, 1 gives pattern bank 0, 2 gives pattern bank 1, 3 gives program bank. Addresses of the first four writes have no effect on the choice.
- R5: The stored value appears on the outputs in the clock cycle after the fifth write. No output changes after writes one to four.
- R6: The program-bank register stores only bits 3:0 of the assembled value.
- R7: An accepted write with data bit 7 set discards the partial value and bit count. It sets control bits 3 and 2 and leaves control bits 4, 1 and 0 unchanged. The next sequence then needs five fresh writes.
- R8: After a store the partial value and count return to zero, so back-to-back sequences each take exactly five writes.
- R9: The internal bit count never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| ctrl_q | output | 5 | Control/mode register |
| pat0_q | output | 5 | Pattern bank 0 selector |
| pat1_q | output | 5 | Pattern bank 1 selector |
| prog_q | output | 4 | Program bank selector |

## Verification
The bench builds the block with its default parameters: a 5-bit serial value, a 4-bit program bank and a 16-bit address. These values allow every destination select code and every serial bit position to be exercised. The bench places escapes after each possible number of partial writes, from zero to four. It also interleaves rejected writes with the strobe low or address bit 15 clear. This shows that neither of these disturbs a sequence in progress.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  typedef enum logic [1:0] {
    DST_CTRL = 2'd0,
    DST_PAT0 = 2'd1,
    DST_PAT1 = 2'd2,
    DST_PROG = 2'd3
  } dst_e;
endpackage

// File: rtl/serial_cfg_shifter.sv
module serial_cfg_shifter #(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             escape,
  input  logic             din,
  output logic             done,
  output logic [VAL_W-1:0] value
);
  localparam int CNT_W = $clog2(VAL_W) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(VAL_W - 1);

  logic [CNT_W-1:0] cnt;
  logic [VAL_W-1:0] acc;
  logic [VAL_W-1:0] nxt;

  always_comb begin
    nxt = acc;
    for (int i = 0; i < VAL_W; i++)
      if (cnt == CNT_W'(i)) nxt[i] = din;
  end

  assign done  = accept && !escape && (cnt == LAST);
  assign value = nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      acc <= '0;
    end else if (accept) begin
      if (escape || cnt == LAST) begin
        cnt <= '0;
        acc <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        acc <= nxt;
      end
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r8_clear_after_commit: assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt == '0 && acc == '0));
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(cnt) && $stable(acc)));
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int VAL_W  = 5,
  parameter int PROG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [1:0]        dst,
  input  logic [VAL_W-1:0]  value,
  input  logic              escape_hit,
  output logic [VAL_W-1:0]  ctrl_q,
  output logic [VAL_W-1:0]  pat0_q,
  output logic [VAL_W-1:0]  pat1_q,
  output logic [PROG_W-1:0] prog_q
);
  import serial_cfg_pkg::*;
  localparam logic [VAL_W-1:0] CTRL_RST  = VAL_W'(5'h0C);
  localparam logic [VAL_W-1:0] CTRL_MODE = VAL_W'(5'h0C);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      pat0_q <= '0;
      pat1_q <= '0;
      prog_q <= '0;
    end else if (escape_hit) begin
      ctrl_q <= ctrl_q | CTRL_MODE;
    end else if (commit) begin
      case (dst_e'(dst))
        DST_CTRL: ctrl_q <= value;
        DST_PAT0: pat0_q <= value;
        DST_PAT1: pat1_q <= value;
        default:  prog_q <= value[PROG_W-1:0];
      endcase
    end
  end

  a_r7_mode_bits: assert property (@(posedge clk) disable iff (rst)
    escape_hit |=> (ctrl_q[3:2] == 2'b11 && ctrl_q[4] == $past(ctrl_q[4])
                    && ctrl_q[1:0] == $past(ctrl_q[1:0])));
  a_r5_hold_no_commit: assert property (@(posedge clk) disable iff (rst)
    (!commit && !escape_hit) |=> ($stable(ctrl_q) && $stable(pat0_q)
                                  && $stable(pat1_q) && $stable(prog_q)));
  a_r6_prog_width: assert property (@(posedge clk) disable iff (rst)
    (commit && dst == 2'd3) |=> prog_q == $past(value[PROG_W-1:0]));
  a_r4_ctrl_dest: assert property (@(posedge clk) disable iff (rst)
    (commit && dst == 2'd0) |=> ctrl_q == $past(value));
endmodule

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int VAL_W  = 5,
  parameter int PROG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VAL_W-1:0]  ctrl_q,
  output logic [VAL_W-1:0]  pat0_q,
  output logic [VAL_W-1:0]  pat1_q,
  output logic [PROG_W-1:0] prog_q
);
  localparam int SEL_LO = ADDR_W - 3;

  logic accept, escape, done;
  logic [VAL_W-1:0] value;

  assign accept = wr_en && wr_addr[ADDR_W-1];
  assign escape = wr_data[DATA_W-1];

  serial_cfg_shifter #(.VAL_W(VAL_W)) u_shift (
    .clk(clk), .rst(rst), .accept(accept), .escape(escape),
    .din(wr_data[0]), .done(done), .value(value)
  );

  serial_cfg_bank #(.VAL_W(VAL_W), .PROG_W(PROG_W)) u_bank (
    .clk(clk), .rst(rst), .commit(done),
    .dst(wr_addr[SEL_LO+1:SEL_LO]), .value(value),
    .escape_hit(accept && escape),
    .ctrl_q(ctrl_q), .pat0_q(pat0_q), .pat1_q(pat1_q), .prog_q(prog_q)
  );

  a_r2_ignore: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(ctrl_q) && $stable(pat0_q) && $stable(pat1_q) && $stable(prog_q)));
endmodule

// File: tb/sim_serial_cfg_regs.sv
module sim_serial_cfg_regs;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [4:0] ctrl_q, pat0_q, pat1_q;
  logic [3:0] prog_q;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  serial_cfg_regs u0 (.*);

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en = 1);
    @(negedge clk); wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(input logic [1:0] sel, input logic [4:0] v);
    for (int i = 0; i < 5; i++) wr({1'b1, (i == 4) ? sel : 2'(3 - sel), 13'h5}, {7'h0, v[i]});
  endtask

  task automatic chk(input string r, input logic [4:0] c, p0, p1, input logic [3:0] pg);
    tests++;
    if (ctrl_q !== c || pat0_q !== p0 || pat1_q !== p1 || prog_q !== pg) begin
      fails++;
      $display("FAIL %s act=%h/%h/%h/%h exp=%h/%h/%h/%h", r, ctrl_q, pat0_q, pat1_q, prog_q, c, p0, p1, pg);
    end
  endtask

  task automatic t_reset; chk("R1", 5'h0C, 0, 0, 0); endtask

  task automatic t_dest;
    load(2'd1, 5'h13); chk("R4 R3 pat0", 5'h0C, 5'h13, 0, 0);
    load(2'd2, 5'h0A); chk("R4 pat1", 5'h0C, 5'h13, 5'h0A, 0);
    load(2'd3, 5'h1B); chk("R6 prog", 5'h0C, 5'h13, 5'h0A, 4'hB);
    load(2'd0, 5'h11); chk("R4 ctrl", 5'h11, 5'h13, 5'h0A, 4'hB);
  endtask

  task automatic t_timing;
    for (int i = 0; i < 4; i++) begin
      wr(16'hA000, 8'h01); chk("R5 no early", 5'h11, 5'h13, 5'h0A, 4'hB);
    end
    @(negedge clk); wr_en = 1; wr_addr = 16'hA000; wr_data = 8'h01;
    @(posedge clk); #1 wr_en = 0; chk("R5 next cycle", 5'h11, 5'h1F, 5'h0A, 4'hB);
  endtask

  task automatic t_ignore;
    wr(16'hA000, 8'h00); wr(16'hA000, 8'h01);
    wr(16'hA000, 8'h01, 0); wr(16'h2000, 8'h01); wr(16'h7FFF, 8'h80);
    chk("R2 ignored", 5'h11, 5'h1F, 5'h0A, 4'hB);
    wr(16'hA000, 8'h00); wr(16'hA000, 8'h00); wr(16'hA000, 8'h00);
    chk("R2 resume pat0", 5'h11, 5'h02, 5'h0A, 4'hB);
  endtask

  task automatic t_escape;
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < k; i++) wr(16'hE000, 8'h01);
      wr(16'h8000, 8'h80);
      load(2'd3, 5'h05 + 5'(k));
      chk("R7 escape", 5'h1D, 5'h02, 5'h0A, 4'(5 + k));
    end
    load(2'd0, 5'h12); wr(16'h8000, 8'hFF);
    chk("R7 keep bits", 5'h1E, 5'h02, 5'h0A, 4'h9);
  endtask

  task automatic t_backtoback;
    load(2'd2, 5'h01); load(2'd2, 5'h10);
    chk("R8 second seq", 5'h1E, 5'h02, 5'h10, 4'h9);
    wr(16'hC000, 8'h01); chk("R9 partial", 5'h1E, 5'h02, 5'h10, 4'h9);
    wr(16'h8000, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_dest(); t_timing(); t_ignore(); t_escape(); t_backtoback();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule